// File: doc/BRIEF.md
# Pixel Frame Readout Sequencer

This block drives the address and marker timing for a pixel array that is split into four subframes read side by side. All four subframes share one address sequence, so each pixel slot selects one pixel in every subframe at once. The sequencer runs from a single readout clock. A start token, active on its falling edge, begins a frame, and a later token aborts the current frame and begins a new one. After a fixed initialisation phase it emits frames back to back for as long as the clock runs.

Every row is emitted as two dummy marker slots followed by one slot per column. Rows count down from the top row to row 0, and columns count down within a row. Besides the shared row and column addresses and a slot-kind code, the block drives a test-level select and a set of digital markers: an init-done pulse, a readout-start pulse, a frame strobe with two forms, a last-column flag and a last-row flag. A strobe-mode input picks the form of the frame strobe. A test-mode input replaces pixel readout with two alternating test levels.

The block has no data stream, so all pins are plain control and status signals with no handshake. The slot outputs decode registered state directly. They change just after the clock edge that advances the sequence and stay stable for the whole cycle.

Top module: `pxseq_top`

## Requirements
- R1: After the active-low asynchronous reset, the block is idle. `slot_kind` is 00, the addresses are 0 and all markers are low. A `sync_in` that has stayed low since reset never starts a frame; only a high-to-low change seen on two successive rising edges does.
- R2: The edge that samples `sync_in` low after a high sample is the start edge. `init_done` is high for exactly the cycle after that edge. The first marker slot is driven in the cycle after the 4th rising edge following the start edge.
- R3: `slot_kind` encodes 10 for the first marker, 01 for the second marker and 11 for a pixel. Each row is the first marker, then the second marker, then 64 pixel slots, which is 66 slots per row. The code is 00 while idle or initialising.
- R4: `row_addr` runs from 255 down to 0, one row per 66 slots. `col_addr` runs from 63 down to 0 across the pixel slots and reads 63 during marker slots. No column is ever skipped. Both addresses read 0 while idle or initialising.
- R5: Outside test mode, `last_col` is high exactly in the pixel slot of column 0. `last_row` is high for every slot of row 0.
- R6: With `strobe_mode` = 0 and test mode off, `frame_strobe` is high only in the first-marker slot of row 255, which opens each frame.
- R7: With `strobe_mode` = 1, or in test mode, `frame_strobe` toggles on every slot. It is high in the first slot of a frame, so its edges mark each slot change.
- R8: Frames follow each other without a gap; the slot after row 0 column 0 is the first marker of row 255. A new start edge at any time, including during initialisation, aborts the sequence and restarts the initialisation phase.
- R9: In test mode, `test_sel` is 1 in pixel slots of odd columns and 0 in pixel slots of even columns. Markers keep their normal order, and `last_col` and `last_row` stay low. `test_sel` is 0 at all other times.
- R10: `ro_start` is high for exactly one cycle after a start edge: the cycle in which the first marker slot is driven. It does not repeat on later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | Start token, acts on its falling edge |
| strobe_mode | input | 1 | 0: strobe once per frame, 1: strobe toggles per slot |
| test_mode | input | 1 | 1: pixel slots carry alternating test levels |
| row_addr | output | 8 | Shared row address |
| col_addr | output | 6 | Shared local column address |
| slot_kind | output | 2 | 00 none, 10 first marker, 01 second marker, 11 pixel |
| test_sel | output | 1 | Test level select, 1 = upper level |
| init_done | output | 1 | One-cycle pulse ending the token-driven reset |
| ro_start | output | 1 | One-cycle pulse with the first marker after a start |
| frame_strobe | output | 1 | Frame or per-slot strobe |
| last_col | output | 1 | Final pixel of a row selected |
| last_row | output | 1 | Final row of the frame selected |

## Verification
`init_done` is due in the cycle right after the start edge. The first slot is due after the 4th edge that follows the start edge. From then on, every output is due in the cycle right after the edge that advances the slot, because all of them decode registered state without an extra pipeline stage. The bench keeps a slot counter that starts at the start edge and advances on every rising edge. It drives inputs and compares every output at the falling edge, so each comparison sees the settled result of the previous rising edge. Random segment lengths, random mode bits and random restarts are mixed with directed cases: a token held low since reset, a restart during initialisation, a full frame with its wrap, and a reset during a frame.

// File: rtl/pxseq_pkg.sv
package pxseq_pkg;
  typedef enum logic [1:0] {
    SLOT_NONE = 2'b00,
    SLOT_MK0  = 2'b01,
    SLOT_MK1  = 2'b10,
    SLOT_PIX  = 2'b11
  } slot_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_INIT = 2'b01,
    ST_RUN  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/pxseq_sync_edge.sv
module pxseq_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic start
);
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  // falling edge seen on two successive rising-edge samples
  assign start = sync_q & ~sync_in;
endmodule

// File: rtl/pxseq_frame_ctrl.sv
module pxseq_frame_ctrl
  import pxseq_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic init_first,
  output logic run_first
);
  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LAT - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      run_first <= 1'b0;
    end else if (start) begin
      state     <= ST_INIT;
      cnt       <= CNT_TOP;
      run_first <= 1'b0;
    end else begin
      run_first <= 1'b0;
      if (state == ST_INIT) begin
        if (cnt == '0) begin
          state     <= ST_RUN;
          run_first <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign running    = (state == ST_RUN);
  assign init_first = (state == ST_INIT) && (cnt == CNT_TOP);

  // R2: the init phase ends in the run state with the first-slot flag set
  a_r2_init_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INIT && cnt == '0 && !start) |=> (running && run_first));
endmodule

// File: rtl/pxseq_scan_ctr.sv
module pxseq_scan_ctr
  import pxseq_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int COLS = 64,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  output slot_e            phase,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  localparam logic [ROW_W-1:0] ROW_TOP = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_TOP = COL_W'(COLS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= SLOT_MK1;
      row   <= ROW_TOP;
      col   <= COL_TOP;
    end else if (load) begin
      phase <= SLOT_MK1;
      row   <= ROW_TOP;
      col   <= COL_TOP;
    end else if (adv) begin
      unique case (phase)
        SLOT_MK1: phase <= SLOT_MK0;
        SLOT_MK0: phase <= SLOT_PIX;
        SLOT_PIX: begin
          if (col == '0) begin
            col   <= COL_TOP;
            phase <= SLOT_MK1;
            row   <= (row == '0) ? ROW_TOP : row - 1'b1;
          end else begin
            col <= col - 1'b1;
          end
        end
        default: phase <= SLOT_MK1;
      endcase
    end
  end

  // R3: the second marker always follows the first
  a_r3_mk0_after_mk1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && phase == SLOT_MK1) |=> (phase == SLOT_MK0));

  // R4: rows step down by one at the end of a row
  a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && phase == SLOT_PIX && col == '0 && row != '0)
      |=> (row == $past(row) - 1'b1));

  // R8: the frame wraps from row 0 to the top row
  a_r8_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && phase == SLOT_PIX && col == '0 && row == '0)
      |=> (row == ROW_TOP && phase == SLOT_MK1));
endmodule

// File: rtl/pxseq_marker_gen.sv
module pxseq_marker_gen
  import pxseq_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int COLS = 64,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             running,
  input  slot_e            phase,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             strobe_mode,
  input  logic             test_mode,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic [1:0]       slot_kind,
  output logic             test_sel,
  output logic             frame_strobe,
  output logic             last_col,
  output logic             last_row
);
  localparam logic [ROW_W-1:0] ROW_TOP = ROW_W'(ROWS - 1);

  logic tog;
  logic is_pix;
  logic per_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog <= 1'b0;
    else if (start)   tog <= 1'b1;
    else if (running) tog <= ~tog;
  end

  always_comb begin
    is_pix       = running && (phase == SLOT_PIX);
    per_slot     = strobe_mode || test_mode;
    slot_kind    = running ? phase : SLOT_NONE;
    row_addr     = running ? row : '0;
    col_addr     = running ? col : '0;
    test_sel     = test_mode && is_pix && col[0];
    last_col     = !test_mode && is_pix && (col == '0);
    last_row     = !test_mode && running && (row == '0);
    frame_strobe = running &&
                   (per_slot ? tog : (phase == SLOT_MK1 && row == ROW_TOP));
  end

  // R5: the last-column flag only marks a pixel slot at column 0
  a_r5_lastcol_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    last_col |-> (slot_kind == SLOT_PIX && col_addr == '0));

  // R9: no end flags while test levels are read
  a_r9_test_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (!last_col && !last_row));

  // R7: the per-slot strobe alternates from one running cycle to the next
  a_r7_strobe_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (running && per_slot && !start) |=> (running && per_slot) |-> (tog != $past(tog)));
endmodule

// File: rtl/pxseq_top.sv
module pxseq_top
  import pxseq_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int COLS = 64,
  parameter int LAT  = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             strobe_mode,
  input  logic             test_mode,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic [1:0]       slot_kind,
  output logic             test_sel,
  output logic             init_done,
  output logic             ro_start,
  output logic             frame_strobe,
  output logic             last_col,
  output logic             last_row
);
  logic             start;
  logic             running;
  logic             init_first;
  logic             run_first;
  slot_e            phase;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  pxseq_sync_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .start   (start)
  );

  pxseq_frame_ctrl #(.LAT(LAT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .running    (running),
    .init_first (init_first),
    .run_first  (run_first)
  );

  pxseq_scan_ctr #(.ROWS(ROWS), .COLS(COLS)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .adv   (running),
    .phase (phase),
    .row   (row),
    .col   (col)
  );

  pxseq_marker_gen #(.ROWS(ROWS), .COLS(COLS)) u_mark (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .running      (running),
    .phase        (phase),
    .row          (row),
    .col          (col),
    .strobe_mode  (strobe_mode),
    .test_mode    (test_mode),
    .row_addr     (row_addr),
    .col_addr     (col_addr),
    .slot_kind    (slot_kind),
    .test_sel     (test_sel),
    .frame_strobe (frame_strobe),
    .last_col     (last_col),
    .last_row     (last_row)
  );

  assign init_done = init_first;
  assign ro_start  = run_first;

  // R10: the readout-start pulse coincides with the first marker of the top row
  a_r10_start_on_first_marker: assert property (@(posedge clk) disable iff (!rst_n)
    ro_start |-> (slot_kind == SLOT_MK1 && row_addr == ROW_W'(ROWS - 1)));

  // R1: nothing is emitted while not running
  a_r1_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kind == SLOT_NONE) |-> (!last_col && !last_row && !frame_strobe && !test_sel));
endmodule

// File: tb/pxseq_top_tb.sv
module pxseq_top_tb;
  localparam int ROWS  = 256;
  localparam int COLS  = 64;
  localparam int LAT   = 4;
  localparam int SLOTS = COLS + 2;
  localparam int FRAME = ROWS * SLOTS;

  logic       clk = 1'b0;
  logic       rst_n, sync_in, strobe_mode, test_mode;
  logic [7:0] row_addr;
  logic [5:0] col_addr;
  logic [1:0] slot_kind;
  logic       test_sel, init_done, ro_start, frame_strobe, last_col, last_row;

  always #4 clk = ~clk;

  pxseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .strobe_mode(strobe_mode),
    .test_mode(test_mode), .row_addr(row_addr), .col_addr(col_addr),
    .slot_kind(slot_kind), .test_sel(test_sel), .init_done(init_done),
    .ro_start(ro_start), .frame_strobe(frame_strobe), .last_col(last_col),
    .last_row(last_row)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit m_run   = 1'b0;   // model: sequence active (init or run)
  int m_t     = 0;      // model: cycles since the start edge
  bit m_prev  = 1'b0;   // model: last sampled token

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      if (n_fail < 40) $display("FAIL %s t=%0d act=%0d exp=%0d", req, m_t, act, exp);
    end
  endtask

  task automatic check_now();
    int e_slot = 0, e_row = 0, e_col = 0, e_id = 0, e_rs = 0;
    int e_fs = 0, e_ts = 0, e_lc = 0, e_lr = 0;
    string fs_req;
    fs_req = (strobe_mode || test_mode) ? "R7 strobe" : "R6 strobe";
    if (m_run) begin
      if (m_t == 0) e_id = 1;
      if (m_t >= LAT) begin
        int s = m_t - LAT;
        int p = s % FRAME;
        int k = p % SLOTS;
        e_row = ROWS - 1 - p / SLOTS;
        if (k == 0)      begin e_slot = 2; e_col = COLS - 1; end
        else if (k == 1) begin e_slot = 1; e_col = COLS - 1; end
        else             begin e_slot = 3; e_col = SLOTS - 1 - k; end
        e_rs = (s == 0);
        e_fs = (strobe_mode || test_mode) ? int'(s % 2 == 0) : int'(p == 0);
        e_ts = int'(test_mode && e_slot == 3 && (e_col % 2 == 1));
        e_lc = int'(!test_mode && e_slot == 3 && e_col == 0);
        e_lr = int'(!test_mode && e_row == 0);
      end
    end
    if (!m_run) begin
      chk("R1 slot_kind idle", slot_kind, 0);
      chk("R1 row idle", row_addr, 0);
      chk("R1 col idle", col_addr, 0);
      chk("R1 init_done idle", init_done, 0);
      chk("R1 ro_start idle", ro_start, 0);
      chk("R1 strobe idle", frame_strobe, 0);
      chk("R1 last_col idle", last_col, 0);
      chk("R1 last_row idle", last_row, 0);
      chk("R1 test_sel idle", test_sel, 0);
    end else begin
      chk("R3 slot_kind", slot_kind, e_slot);
      chk("R4 row_addr", row_addr, e_row);
      chk("R4 col_addr", col_addr, e_col);
      chk("R2 init_done", init_done, e_id);
      chk("R10 ro_start", ro_start, e_rs);
      chk(fs_req, frame_strobe, e_fs);
      chk(test_mode ? "R9 last_col" : "R5 last_col", last_col, e_lc);
      chk(test_mode ? "R9 last_row" : "R5 last_row", last_row, e_lr);
      chk("R9 test_sel", test_sel, e_ts);
    end
  endtask

  // check the settled outputs, then set the token for the next rising edge
  task automatic tick(bit nsync);
    @(negedge clk);
    check_now();
    sync_in = nsync;
    if (m_prev && !nsync) begin m_run = 1'b1; m_t = 0; end
    else if (m_run) m_t++;
    m_prev = nsync;
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic restart();   // R8: token high for one cycle, then low
    tick(1'b1);
    tick(1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; sync_in = 1'b0; strobe_mode = 1'b0; test_mode = 1'b0;
    #20;
    @(negedge clk);
    check_now();                 // R1 reset state
    rst_n = 1'b1;
    run_cycles(12);              // R1 token low since reset: stays idle

    // R2 R3 R4 R5 R6 R8 R10: one full frame plus the wrap
    restart();
    run_cycles(FRAME + 300);

    // R7 per-slot strobe
    strobe_mode = 1'b1;
    run_cycles(500);

    // R8 abort mid-frame, then R9 test mode
    restart();
    test_mode = 1'b1;
    run_cycles(700);

    // R8 restart during the init phase
    strobe_mode = 1'b0; test_mode = 1'b0;
    restart();
    run_cycles(2);
    restart();
    run_cycles(200);

    // random segments
    for (int i = 0; i < 24; i++) begin
      strobe_mode = 1'($urandom_range(0, 1));
      test_mode   = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1) == 1) restart();
      run_cycles(int'($urandom_range(20, 3000)));
    end

    // R1 asynchronous reset during a frame
    @(negedge clk);
    rst_n = 1'b0; sync_in = 1'b0;
    m_run = 1'b0; m_prev = 1'b0;
    #1;
    check_now();
    @(negedge clk);
    rst_n = 1'b1;
    run_cycles(10);
    restart();
    run_cycles(SLOTS * 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule